// File: doc/BRIEF.md
# Programmable Priority Interrupt Level Controller

This block gathers interrupt requests from sixteen on-chip peripheral sources and two off-chip interrupt pins. It then presents one prioritized request to a processor. Software gives each source a 3-bit level number. That number places the source on one of eight strictly ordered interrupt levels, and any number of sources may be placed on the same level. A level counts as pending while at least one of its sources is active.

The processor sees one request line, `irq_req`, and the number of the most urgent level that is both pending and enabled, `irq_level`. Level 7 is the most urgent and level 0 the least. Each of the two pins is brought through a two-stage synchronizer. Each pin can then be used either as a level-sensitive input or as a rising-edge input. In edge mode the event is held until software acknowledges it by writing a level number.

A small register port holds the level assignments, the per-level enables and the pin modes. The same port returns the pending status and accepts acknowledges. Its read data is combinational on the address. A write takes effect at the clock edge on which `cfg_wr` is sampled high.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, every level assignment reads 0, the enable register reads 0, both pins are in level mode, the pending status reads 0 and `irq_req` is low.
- R2: An internal source is active while its input is high. The pending bit of the level assigned to that source is set in the status register (address 21, bit n = level n) one clock edge after the source goes high.
- R3: With several sources on one level, the level stays pending while any of them is high, and clears one clock edge after the last one goes low.
- R4: The level assignment of source s sits in bits [2:0] of address s. Sources 0 to 15 are the internal inputs and sources 16 and 17 are pins 0 and 1. Writes keep only those three bits, and reads return them with zeros above.
- R5: The enable register at address 21−1 = 20 holds one enable per level (bit n = level n). A disabled level still shows in the status register but never raises `irq_req`.
- R6: `irq_req` is high exactly when some level is both pending and enabled. `irq_level` then gives the highest such level, where 7 beats 0.
- R7: A pin in level mode is active while it is high. The effect reaches the status register three clock edges after the pin changes: two edges in the synchronizer and one in the pending register.
- R8: The pin mode register at address 23 has bit j = 1 to put pin j in rising-edge mode. In that mode a rising edge on the synchronized pin latches an event that stays pending after the pin falls.
- R9: Writing a level number to bits [2:0] of address 22 clears the latched events of every edge-mode pin assigned to that level. The pending status drops one edge after the write. Events on other levels and internal sources are unaffected. If a new edge is detected on the same edge as the acknowledge, the new event is kept.
- R10: Changing a source's level assignment while the source is active moves its pending bit to the new level one clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_src | input | 16 | Internal source requests, active high |
| ext_pin | input | 2 | Off-chip interrupt pins, asynchronous |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| irq_req | output | 1 | Request to the processor |
| irq_level | output | 3 | Highest enabled pending level |

## Verification
The results arrive at fixed delays:
- An internal source reaches the status register and the request outputs one edge after it changes.
- A register write or an acknowledge reaches the status register one edge after the write edge.
- A level-mode pin reaches the status register three edges after it changes, and an edge-mode pin four.

Every stimulus in the bench is driven on a falling edge, and the bench counts exactly that many rising edges before it samples at a later falling edge. For the pin checks, the bench also samples one edge early to confirm that the result is not visible too soon.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned N_LVL  = 1 << LVL_W;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = N_LVL;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t ADR_ENABLE = 5'd20;
  localparam addr_t ADR_STATUS = 5'd21;
  localparam addr_t ADR_ACK    = 5'd22;
  localparam addr_t ADR_MODE   = 5'd23;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 18,
  parameter int unsigned N_EXT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  addr_t               addr,
  input  data_t               wdata,
  input  logic [N_LVL-1:0]    status,
  output lvl_t [N_SRC-1:0]    map,
  output logic [N_LVL-1:0]    en,
  output logic [N_EXT-1:0]    mode,
  output logic                ack_valid,
  output lvl_t                ack_lvl,
  output data_t               rdata
);
  lvl_t [N_SRC-1:0] map_q, map_d;
  logic [N_LVL-1:0] en_q, en_d;
  logic [N_EXT-1:0] mode_q, mode_d;

  always_comb begin
    map_d  = map_q;
    en_d   = en_q;
    mode_d = mode_q;
    if (wr) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (addr == addr_t'(s)) map_d[s] = wdata[LVL_W-1:0];
      end
      if (addr == ADR_ENABLE) en_d = wdata;
      if (addr == ADR_MODE)   mode_d = wdata[N_EXT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      en_q   <= '0;
      mode_q <= '0;
    end else begin
      map_q  <= map_d;
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end

  assign map       = map_q;
  assign en        = en_q;
  assign mode      = mode_q;
  assign ack_valid = wr && (addr == ADR_ACK);
  assign ack_lvl   = wdata[LVL_W-1:0];

  always_comb begin
    rdata = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (addr == addr_t'(s)) rdata = data_t'(map_q[s]);
    end
    case (addr)
      ADR_ENABLE: rdata = en_q;
      ADR_STATUS: rdata = status;
      ADR_MODE:   rdata = data_t'(mode_q);
      default: ;
    endcase
  end

  AST_ACK_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADR_ACK) |=> ($stable(en_q) && $stable(map_q) && $stable(mode_q))); // R9
endmodule

// File: rtl/irqc_ext.sv
module irqc_ext
  import irqc_pkg::*;
#(
  parameter int unsigned N_EXT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  pin,
  input  logic [N_EXT-1:0]  edge_mode,
  input  lvl_t [N_EXT-1:0]  pin_map,
  input  logic              ack_valid,
  input  lvl_t              ack_lvl,
  output logic [N_EXT-1:0]  active
);
  for (genvar j = 0; j < N_EXT; j++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    logic evt_q, evt_d;
    logic rise, clr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin[j];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign rise = s2_q & ~s3_q;
    assign clr  = ack_valid && (pin_map[j] == ack_lvl);

    always_comb begin
      evt_d = evt_q;
      if (clr)                 evt_d = 1'b0;
      if (!edge_mode[j])       evt_d = 1'b0;
      else if (rise)           evt_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= evt_d;
    end

    assign active[j] = edge_mode[j] ? evt_q : s2_q;

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[j] && evt_q && !clr) |=> evt_q); // R8
    AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[j] && clr && !rise) |=> !evt_q); // R9
    AST_EDGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[j] && rise) |=> evt_q); // R9
  end
endmodule

// File: rtl/irqc_route.sv
module irqc_route
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_act,
  input  lvl_t [N_SRC-1:0]  map,
  output logic [N_LVL-1:0]  pend
);
  logic [N_LVL-1:0] pend_d, pend_q;

  always_comb begin
    pend_d = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (src_act[s]) pend_d[map[s]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  AST_QUIET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_act == '0) |=> (pend_q == '0)); // R3
  AST_ACTIVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_act != '0) |=> (pend_q != '0)); // R2
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [N_LVL-1:0] pend,
  input  logic [N_LVL-1:0] en,
  output logic             req,
  output lvl_t             lvl
);
  always_comb begin
    req = 1'b0;
    lvl = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if (pend[l] && en[l]) begin
        req = 1'b1;
        lvl = lvl_t'(l);
      end
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_INT = 16,
  parameter int unsigned N_EXT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  int_src,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic              cfg_wr,
  input  logic [4:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              irq_req,
  output logic [2:0]        irq_level
);
  localparam int unsigned N_SRC = N_INT + N_EXT;

  logic             rs1_q, rs2_q;
  logic             rst_core_n;
  lvl_t [N_SRC-1:0] map;
  logic [N_LVL-1:0] en, pend;
  logic [N_EXT-1:0] mode, ext_act;
  logic             ack_valid;
  lvl_t             ack_lvl;
  logic [N_SRC-1:0] src_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_core_n = rs2_q;

  irqc_regs #(.N_SRC(N_SRC), .N_EXT(N_EXT)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .status(pend), .map(map), .en(en), .mode(mode),
    .ack_valid(ack_valid), .ack_lvl(ack_lvl), .rdata(cfg_rdata)
  );

  irqc_ext #(.N_EXT(N_EXT)) u_ext (
    .clk(clk), .rst_n(rst_core_n), .pin(ext_pin), .edge_mode(mode),
    .pin_map(map[N_SRC-1:N_INT]), .ack_valid(ack_valid), .ack_lvl(ack_lvl),
    .active(ext_act)
  );

  assign src_act = {ext_act, int_src};

  irqc_route #(.N_SRC(N_SRC)) u_route (
    .clk(clk), .rst_n(rst_core_n), .src_act(src_act), .map(map), .pend(pend)
  );

  irqc_prio u_prio (.pend(pend), .en(en), .req(irq_req), .lvl(irq_level));

  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_req |-> (en[irq_level] && pend[irq_level])); // R5
  AST_NONE_ABOVE: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_req |-> (((pend & en) >> irq_level) == 8'd1)); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((pend & en) == '0) |-> !irq_req); // R6
endmodule

// File: tb/sim_irq_level_ctrl.sv
module sim_irq_level_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] int_src;
  logic [1:0]  ext_pin;
  logic        cfg_wr;
  logic [4:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        irq_req;
  logic [2:0]  irq_level;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .int_src(int_src), .ext_pin(ext_pin),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_req(irq_req), .irq_level(irq_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 irq_req", irq_req, 0);
    rd(5'd20, d); chk("R1 enable", d, 0);
    rd(5'd21, d); chk("R1 status", d, 0);
    rd(5'd23, d); chk("R1 mode", d, 0);
    rd(5'd0, d);  chk("R1 map0", d, 0);
    rd(5'd17, d); chk("R1 map17", d, 0);
  endtask

  task automatic t_map_rw;
    logic [7:0] d;
    wr(5'd5, 8'hF6);  rd(5'd5, d);  chk("R4 map5", d, 6);
    wr(5'd17, 8'h03); rd(5'd17, d); chk("R4 map17", d, 3);
    rd(5'd4, d); chk("R4 map4 untouched", d, 0);
  endtask

  task automatic t_internal;
    logic [7:0] d;
    wr(5'd20, 8'hFF);
    wr(5'd3, 8'd4);
    int_src[3] = 1'b1;
    rd(5'd21, d); chk("R2 not yet", d, 0);
    cyc(1);
    rd(5'd21, d); chk("R2 status", d, 8'h10);
    chk("R6 req", irq_req, 1);
    chk("R6 level", irq_level, 4);
  endtask

  task automatic t_share;
    logic [7:0] d;
    wr(5'd7, 8'd4);
    int_src[7] = 1'b1; cyc(1);
    int_src[3] = 1'b0; cyc(1);
    rd(5'd21, d); chk("R3 shared held", d, 8'h10);
    int_src[7] = 1'b0; cyc(1);
    rd(5'd21, d); chk("R3 shared cleared", d, 0);
    chk("R6 no req", irq_req, 0);
  endtask

  task automatic t_prio;
    logic [7:0] d;
    wr(5'd1, 8'd2); wr(5'd9, 8'd6); wr(5'd12, 8'd0);
    int_src[1] = 1'b1; int_src[9] = 1'b1; int_src[12] = 1'b1;
    cyc(1);
    chk("R6 highest", irq_level, 6);
    wr(5'd20, 8'hBF);
    chk("R5 masked level", irq_level, 2);
    rd(5'd21, d); chk("R5 status keeps masked", d, 8'h45);
    wr(5'd20, 8'h00);
    chk("R5 all masked", irq_req, 0);
    rd(5'd21, d); chk("R5 status all masked", d, 8'h45);
    wr(5'd20, 8'hFF);
    int_src[1] = 1'b0; int_src[12] = 1'b0;
    cyc(1);
  endtask

  task automatic t_remap;
    logic [7:0] d;
    wr(5'd9, 8'd1);
    rd(5'd21, d); chk("R10 before move", d, 8'h40);
    cyc(1);
    rd(5'd21, d); chk("R10 moved", d, 8'h02);
    chk("R10 level", irq_level, 1);
    int_src[9] = 1'b0; cyc(1);
  endtask

  task automatic t_ext_level;
    logic [7:0] d;
    wr(5'd16, 8'd5);
    ext_pin[0] = 1'b1;
    cyc(2);
    rd(5'd21, d); chk("R7 early", d, 0);
    cyc(1);
    rd(5'd21, d); chk("R7 level pin", d, 8'h20);
    ext_pin[0] = 1'b0;
    cyc(3);
    rd(5'd21, d); chk("R7 level pin released", d, 0);
  endtask

  task automatic t_ext_edge;
    logic [7:0] d;
    wr(5'd23, 8'h02);
    wr(5'd17, 8'd7);
    ext_pin[1] = 1'b1; cyc(2);
    ext_pin[1] = 1'b0; cyc(5);
    rd(5'd21, d); chk("R8 edge latched", d, 8'h80);
    chk("R8 level", irq_level, 7);
    wr(5'd0, 8'd7);
    int_src[0] = 1'b1;
    wr(5'd22, 8'd3); cyc(1);
    rd(5'd21, d); chk("R9 other ack", d, 8'h80);
    int_src[0] = 1'b0;
    wr(5'd22, 8'd7); cyc(1);
    rd(5'd21, d); chk("R9 acked", d, 0);
    int_src[0] = 1'b1;
    ext_pin[1] = 1'b1; cyc(5);
    wr(5'd22, 8'd7); cyc(1);
    rd(5'd21, d); chk("R9 internal unaffected", d, 8'h80);
    int_src[0] = 1'b0; cyc(1);
    rd(5'd21, d); chk("R9 pin high no new edge", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; int_src = '0; ext_pin = '0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset;
    t_map_rw;
    t_internal;
    t_share;
    t_prio;
    t_remap;
    t_ext_level;
    t_ext_edge;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule